// File: doc/BRIEF.md
# Stereo Channel Mixing and Mute Stage

This stage sits in a stereo playback datapath between the sample source and the output converters. Each valid-qualified pair of 24-bit signed samples (left and right) produces one pair of output samples, channel A and channel B. A 5-bit mixing code picks what feeds each output: silence, the left input, the right input, or the mean of both. Routing is followed by a per-channel mute and a per-channel polarity flip.

A gang control ties channel B's mute and polarity settings to channel A's, so one set of controls drives both outputs. The gang control does not change routing. Results are registered, so a sample pair shows up one clock after it was accepted. Between valid samples the outputs hold their last values. The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `chmix_stage`

## Requirements
- R1: While in reset and until the first accepted sample, out_valid is 0 and out_a and out_b are 0.
- R2: out_valid is high exactly one clock after each clock in which in_valid was high. When in_valid is low, out_a and out_b keep their previous values whatever the other inputs do.
- R3: mix_code bits 3:2 pick channel A's source: 00 silence (zero), 01 right, 10 left, 11 average.
- R4: mix_code bits 1:0 pick channel B's source using the same encoding: 00 silence, 01 right, 10 left, 11 average.
- R5: The average is floor((left+right)/2), formed at 25 bits and shifted arithmetically, so it never overflows even for two full-scale inputs of the same sign.
- R6: mix_code bit 4 is reserved and has no effect on either output.
- R7: A set mute bit forces that channel's output to zero, whatever its source or invert setting.
- R8: A set invert bit (default off) outputs the two's complement negation of the routed sample on that channel.
- R9: Inverting the most negative value (0x800000) gives the most positive value (0x7FFFFF) instead of wrapping.
- R10: With gang high, channel B uses mute_a and inv_a, and mute_b and inv_b are ignored. With gang low, each channel uses its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample pair is presented this clock |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| mix_code | input | 5 | Routing code; bits 3:2 for A, bits 1:0 for B, bit 4 reserved |
| gang | input | 1 | Channel B takes channel A's mute and invert settings |
| mute_a | input | 1 | Silence channel A |
| mute_b | input | 1 | Silence channel B (ignored while ganged) |
| inv_a | input | 1 | Negate channel A |
| inv_b | input | 1 | Negate channel B (ignored while ganged) |
| out_valid | output | 1 | Output pair updated this clock |
| out_a | output | 24 | Channel A output sample |
| out_b | output | 24 | Channel B output sample |

## Verification
Random sample pairs are sent through all 32 mixing codes with random mute, invert and gang settings. Random data makes left, right and average sources give different values, so a swapped or misdecoded selection shows up at the outputs. Directed pairs cover cases random data rarely hits. Two full-scale positives and two full-scale negatives separate a 25-bit average from a wrapping one, and an odd negative sum exposes rounding toward zero. 0x800000 under invert tells saturation apart from wrap. Other directed cases set mute together with invert, change mute_b and inv_b while ganged, and change the inputs while in_valid is low to prove the hold.

// File: rtl/chmix_pkg.sv
package chmix_pkg;
  // Source choice for one output channel, encoded as in the mixing code fields.
  typedef enum logic [1:0] {
    SRC_SILENT = 2'b00,
    SRC_RIGHT  = 2'b01,
    SRC_LEFT   = 2'b10,
    SRC_MEAN   = 2'b11
  } src_sel_e;

  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned SEL_A_LO = 2;
  localparam int unsigned SEL_B_LO = 0;
endpackage

// File: rtl/chmix_ctrl.sv
module chmix_ctrl
  import chmix_pkg::*;
(
  input  logic [CODE_W-1:0] mix_code,
  input  logic              gang,
  input  logic              mute_a,
  input  logic              mute_b,
  input  logic              inv_a,
  input  logic              inv_b,
  output src_sel_e          sel   [NUM_CH],
  output logic [NUM_CH-1:0] mute_eff,
  output logic [NUM_CH-1:0] inv_eff
);
  logic unused_reserved;

  // Bit 4 of the code is reserved and does not reach the datapath.
  assign unused_reserved = mix_code[CODE_W-1];

  always_comb begin
    sel[0]      = src_sel_e'(mix_code[SEL_A_LO +: 2]);
    sel[1]      = src_sel_e'(mix_code[SEL_B_LO +: 2]);
    mute_eff[0] = mute_a;
    inv_eff[0]  = inv_a;
    if (gang) begin
      mute_eff[1] = mute_a;
      inv_eff[1]  = inv_a;
    end else begin
      mute_eff[1] = mute_b;
      inv_eff[1]  = inv_b;
    end
  end
endmodule

// File: rtl/chmix_route.sv
module chmix_route
  import chmix_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] left,
  input  logic [W-1:0] right,
  input  src_sel_e     sel,
  output logic [W-1:0] routed
);
  localparam int unsigned SUM_W = W + 1;

  logic signed [SUM_W-1:0] sum;
  logic [W-1:0]            mean;
  logic                    unused_lsb;

  // Sign-extended addition: one extra bit holds any pair of W-bit values.
  assign sum        = $signed({left[W-1], left}) + $signed({right[W-1], right});
  assign mean       = sum[SUM_W-1:1];
  assign unused_lsb = sum[0];

  always_comb begin
    unique case (sel)
      SRC_RIGHT: routed = right;
      SRC_LEFT:  routed = left;
      SRC_MEAN:  routed = mean;
      default:   routed = '0;
    endcase
  end
endmodule

// File: rtl/chmix_polarity.sv
module chmix_polarity #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] sample,
  input  logic         mute,
  input  logic         invert,
  output logic [W-1:0] shaped
);
  localparam logic [W-1:0] NEG_FULL = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_FULL = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (mute) begin
      shaped = '0;
    end else if (invert) begin
      shaped = (sample == NEG_FULL) ? POS_FULL : ('0 - sample);
    end else begin
      shaped = sample;
    end
  end
endmodule

// File: rtl/chmix_stage.sv
module chmix_stage
  import chmix_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      in_left,
  input  logic [W-1:0]      in_right,
  input  logic [CODE_W-1:0] mix_code,
  input  logic              gang,
  input  logic              mute_a,
  input  logic              mute_b,
  input  logic              inv_a,
  input  logic              inv_b,
  output logic              out_valid,
  output logic [W-1:0]      out_a,
  output logic [W-1:0]      out_b
);
  localparam int unsigned SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_q_n;

  src_sel_e          sel [NUM_CH];
  logic [NUM_CH-1:0] mute_eff;
  logic [NUM_CH-1:0] inv_eff;
  logic [W-1:0]      routed [NUM_CH];
  logic [W-1:0]      shaped [NUM_CH];

  logic              valid_d, valid_q;
  logic [W-1:0]      a_d, a_q, b_d, b_q;
  logic              smp_en;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[SYNC_W-1];

  chmix_ctrl u_ctrl (
    .mix_code (mix_code),
    .gang     (gang),
    .mute_a   (mute_a),
    .mute_b   (mute_b),
    .inv_a    (inv_a),
    .inv_b    (inv_b),
    .sel      (sel),
    .mute_eff (mute_eff),
    .inv_eff  (inv_eff)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chmix_route #(.W(W)) u_route (
      .left   (in_left),
      .right  (in_right),
      .sel    (sel[ch]),
      .routed (routed[ch])
    );
    chmix_polarity #(.W(W)) u_pol (
      .sample (routed[ch]),
      .mute   (mute_eff[ch]),
      .invert (inv_eff[ch]),
      .shaped (shaped[ch])
    );
  end

  // Next-state logic.
  always_comb begin
    smp_en  = in_valid;
    valid_d = in_valid;
    a_d     = a_q;
    b_d     = b_q;
    if (smp_en) begin
      a_d = shaped[0];
      b_d = shaped[1];
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      valid_q <= valid_d;
      if (smp_en) begin
        a_q <= a_d;
        b_q <= b_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_a     = a_q;
  assign out_b     = b_q;
endmodule

// File: rtl/chmix_stage_chk.sv
module chmix_stage_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         in_valid,
  input logic [4:0]   mix_code,
  input logic         gang,
  input logic         mute_a,
  input logic         mute_b,
  input logic         inv_a,
  input logic         out_valid,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b
);
  localparam logic [W-1:0] NEG_FULL = {1'b1, {(W-1){1'b0}}};

  // R2: out_valid follows in_valid by one clock
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);
  // R2: outputs hold without a valid sample
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_a) && $stable(out_b)));
  // R3: silent source on channel A
  a_r3_silent_a: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && mix_code[3:2] == 2'b00) |=> (out_a == '0));
  // R4: silent source on channel B
  a_r4_silent_b: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && mix_code[1:0] == 2'b00) |=> (out_b == '0));
  // R7: channel mute
  a_r7_mute_a: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && mute_a) |=> (out_a == '0));
  a_r7_mute_b: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !gang && mute_b) |=> (out_b == '0));
  // R9: an inverted unmuted output never holds the most negative code
  a_r9_no_neg_full: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && inv_a && !mute_a) |=> (out_a != NEG_FULL));
  // R10: ganged channel B takes A's mute
  a_r10_gang_mute: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && gang && mute_a) |=> (out_b == '0));
  // R10: ganged channels with equal routing give equal outputs
  a_r10_gang_same: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && gang && mix_code[3:2] == mix_code[1:0]) |=> (out_a == out_b));
endmodule

bind chmix_stage chmix_stage_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .mix_code  (mix_code),
  .gang      (gang),
  .mute_a    (mute_a),
  .mute_b    (mute_b),
  .inv_a     (inv_a),
  .out_valid (out_valid),
  .out_a     (out_a),
  .out_b     (out_b)
);

// File: tb/chmix_stage_bench.sv
module chmix_stage_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_left, in_right;
  logic [4:0]  mix_code;
  logic        gang, mute_a, mute_b, inv_a, inv_b;
  logic        out_valid;
  logic [23:0] out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  chmix_stage u_chmix_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .mix_code(mix_code),
    .gang(gang), .mute_a(mute_a), .mute_b(mute_b),
    .inv_a(inv_a), .inv_b(inv_b),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Reference: pick a source from a 2-bit field (00 zero, 01 right, 10 left, 11 mean).
  function automatic int pick(input logic [23:0] l, input logic [23:0] r,
                              input logic [1:0] f);
    int li, ri, s;
    li = $signed(l);
    ri = $signed(r);
    s  = li + ri;
    case (f)
      2'd1:    return ri;
      2'd2:    return li;
      2'd3:    return (s < 0 && (s % 2) != 0) ? (s - 1) / 2 : s / 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] finish_ch(input int v, input bit m, input bit inv);
    int x;
    if (m) return 24'd0;
    x = inv ? -v : v;
    if (x > 8388607) x = 8388607;
    return x[23:0];
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one sample pair, then check both outputs one clock later.
  task automatic send(input logic [23:0] l, input logic [23:0] r, input logic [4:0] c,
                      input bit g, input bit ma, input bit mb, input bit ia, input bit ib,
                      input string ra, input string rb);
    logic [23:0] ea, eb;
    in_left = l; in_right = r; mix_code = c; gang = g;
    mute_a = ma; mute_b = mb; inv_a = ia; inv_b = ib; in_valid = 1;
    ea = finish_ch(pick(l, r, c[3:2]), ma, ia);
    eb = finish_ch(pick(l, r, c[1:0]), g ? ma : mb, g ? ia : ib);
    @(negedge clk);
    in_valid = 0;
    chk("R2 valid", {23'd0, out_valid}, 24'd1);
    chk(ra, out_a, ea);
    chk(rb, out_b, eb);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] ha, hb;
    void'($urandom(32'h5EED_2024));
    rst_n = 0; in_valid = 0; in_left = 0; in_right = 0; mix_code = 0;
    gang = 0; mute_a = 0; mute_b = 0; inv_a = 0; inv_b = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {23'd0, out_valid}, 24'd0);
    chk("R1 a in reset", out_a, 24'd0);
    chk("R1 b in reset", out_b, 24'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 a after release", out_a, 24'd0);
    chk("R1 valid after release", {23'd0, out_valid}, 24'd0);

    // Directed routing codes.
    send(24'h123456, 24'h654321, 5'b00000, 0,0,0,0,0, "R3 code0 a", "R4 code0 b");
    send(24'h123456, 24'h654321, 5'b00001, 0,0,0,0,0, "R3 code1 a", "R4 code1 b");
    send(24'h123456, 24'h654321, 5'b00010, 0,0,0,0,0, "R3 code2 a", "R4 code2 b");
    send(24'h123456, 24'h654321, 5'b00011, 0,0,0,0,0, "R3 code3 a", "R4 code3 b");
    send(24'h123456, 24'h654321, 5'b00100, 0,0,0,0,0, "R3 code4 a", "R4 code4 b");
    send(24'h123456, 24'h654321, 5'b01110, 0,0,0,0,0, "R3 code14 a", "R4 code14 b");
    // Mean at full scale and with odd negative sum.
    send(24'h7FFFFF, 24'h7FFFFF, 5'b01111, 0,0,0,0,0, "R5 pos full a", "R5 pos full b");
    send(24'h800000, 24'h800000, 5'b01111, 0,0,0,0,0, "R5 neg full a", "R5 neg full b");
    send(24'hFFFFFF, 24'hFFFFFE, 5'b01111, 0,0,0,0,0, "R5 odd neg a", "R5 odd neg b");
    // Reserved bit.
    send(24'h0A0B0C, 24'hF00001, 5'b11001, 0,0,0,0,0, "R6 bit4 a", "R6 bit4 b");
    // Mute over invert.
    send(24'h111111, 24'h222222, 5'b01010, 0,1,0,1,1, "R7 mute a", "R8 invert b");
    send(24'h111111, 24'h222222, 5'b00101, 0,0,1,1,1, "R8 invert a", "R7 mute b");
    // Saturation.
    send(24'h800000, 24'h800000, 5'b01010, 0,0,0,1,1, "R9 sat a", "R9 sat b");
    // Gang ignores B's own bits.
    send(24'h333333, 24'h444444, 5'b00101, 1,0,1,1,0, "R10 gang a", "R10 gang inv b");
    send(24'h333333, 24'h444444, 5'b00110, 1,1,0,0,1, "R10 gang mute a", "R10 gang mute b");

    // Hold while in_valid is low.
    ha = out_a; hb = out_b;
    in_left = 24'h5A5A5A; in_right = 24'hA5A5A5; mix_code = 5'b01010;
    gang = 0; mute_a = 0; mute_b = 0; inv_a = 1; inv_b = 0;
    repeat (3) @(negedge clk);
    chk("R2 hold a", out_a, ha);
    chk("R2 hold b", out_b, hb);
    chk("R2 idle valid", {23'd0, out_valid}, 24'd0);

    // Random sweep.
    for (int i = 0; i < 400; i++) begin
      logic [23:0] l, r;
      logic [4:0]  c;
      logic [5:0]  f;
      l = $urandom(); r = $urandom(); c = i[4:0]; f = $urandom();
      if (i % 16 == 5) l = 24'h800000;
      send(l, r, c, f[0], f[1] & f[2], f[3] & f[4], f[5], f[2], "R3 random a", "R4 random b");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule